// File: doc/BRIEF.md
# Paged 24-Line Digital I/O Port

This block gives a host bus 24 bidirectional digital lines, grouped as three 8-bit ports (A, B and C). Port C is controlled as two 4-bit halves. Each of the four groups has its own direction bit, and a global enable bit can tristate every pin at once.

The port registers sit at offsets 0x0C to 0x0F. A timer block uses the same offsets. A page bit in the control register at offset 0x08 decides which of the two register sets the bus reaches. In this block the timer page is modelled by three plain scratch bytes, which is enough to exercise the page switching.

Each output latch drives its pins only while its group is an output and the port is enabled. A read of a port register returns the level seen on the pins. The control register also accepts a board-reset command, which puts every latch and the configuration back to their default values.

Top module: `dio24_paged_port`

## Requirements
- R1: After `rst_n` is asserted, all output latches are 0, every `pin_oe` bit is 0, the page bit is 0 (timer page), and the configuration register reads 0x9B.
- R2: A write to offset 0x08 sets the page from bit 0 of the write data: 1 selects the digital I/O page and 0 selects the timer page. The write takes effect at the next clock edge.
- R3: On the digital I/O page, offsets 0x0C, 0x0D and 0x0E write the latches for port A (lines 7:0), port B (lines 15:8) and port C (lines 23:16). The latched value appears on `pin_out` one cycle after the write.
- R4: On the digital I/O page, offset 0x0F is the configuration register, and it is readable. Its direction bits are: bit 4 for port A, bit 1 for port B, bit 0 for lines 19:16 and bit 3 for lines 23:20. A direction bit of 1 makes that group an input (`pin_oe` low) and 0 makes it an output (`pin_oe` high), provided bit 7 is set.
- R5: While bit 7 of the configuration register is 0, every `pin_oe` bit is 0, whatever the direction bits hold.
- R6: On the digital I/O page, a read of 0x0C, 0x0D or 0x0E returns the matching byte of `pin_in`. This holds for groups set as outputs as well as for groups set as inputs.
- R7: An output latch keeps its value while its group is an input. When the group is switched to output, the latch drives the pins.
- R8: A write to offset 0x08 with bit 5 set is a board reset. At the next edge it clears all latches, sets the configuration to 0x9B and sets the page from bit 0.
- R9: On the timer page, offsets 0x0D to 0x0F are three scratch bytes that can be written and read back. Offset 0x0C reads 0x00 and ignores writes. No write on this page changes the port latches or the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 24 | Levels sensed at the pads |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Per-line output enable |

## Verification
The bench walks through all 16 combinations of the four direction bits with the port enabled. It uses two external pad patterns that are complements of each other, so a line that is really driven reads back the same under both patterns, while a line left as input follows the pattern. Repeating the sweep with the enable bit clear shows that the global tristate overrides every direction bit. Writes made on the timer page are then followed by reads on the port page, and the reverse. This catches any leak between the two register sets. It also catches a latch that is lost while its group is an input, or a board reset that clears only part of the state.

// File: rtl/dio24_paged_port.sv
module dio24_paged_port #(
  parameter logic [7:0] CFG_DEFAULT = 8'h9B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [23:0] pin_in,
  output logic [23:0] pin_out,
  output logic [23:0] pin_oe
);
  localparam logic [3:0] A_CTRL = 4'h8, A_P0 = 4'hC, A_P1 = 4'hD, A_P2 = 4'hE, A_P3 = 4'hF;

  logic        page_q;
  logic [7:0]  cfg_q;
  logic [23:0] lat_q;
  logic [7:0]  scr_q [3];

  wire ctl_wr   = bus_wr && bus_addr == A_CTRL;
  wire brd_rst  = ctl_wr && bus_wdata[5];
  wire dio_wr   = bus_wr && page_q;
  wire tmr_wr   = bus_wr && !page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      cfg_q  <= CFG_DEFAULT;
      lat_q  <= '0;
      for (int i = 0; i < 3; i++) scr_q[i] <= '0;
    end else begin
      if (ctl_wr) page_q <= bus_wdata[0];
      if (brd_rst) begin
        cfg_q <= CFG_DEFAULT;
        lat_q <= '0;
      end else if (dio_wr) begin
        case (bus_addr)
          A_P0: lat_q[7:0]   <= bus_wdata;
          A_P1: lat_q[15:8]  <= bus_wdata;
          A_P2: lat_q[23:16] <= bus_wdata;
          A_P3: cfg_q        <= bus_wdata;
          default: ;
        endcase
      end
      if (tmr_wr && bus_addr >= A_P1) scr_q[bus_addr - A_P1] <= bus_wdata;
    end
  end

  wire en = cfg_q[7];
  assign pin_out = lat_q;
  assign pin_oe  = { {4{en & ~cfg_q[3]}}, {4{en & ~cfg_q[0]}},
                     {8{en & ~cfg_q[1]}}, {8{en & ~cfg_q[4]}} };

  always_comb begin
    bus_rdata = 8'h00;
    if (page_q) begin
      case (bus_addr)
        A_P0: bus_rdata = pin_in[7:0];
        A_P1: bus_rdata = pin_in[15:8];
        A_P2: bus_rdata = pin_in[23:16];
        A_P3: bus_rdata = cfg_q;
        default: ;
      endcase
    end else if (bus_addr >= A_P1) begin
      bus_rdata = scr_q[bus_addr - A_P1];
    end
  end

  // R4
  all_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_wr && bus_addr == A_P3 && bus_wdata == 8'h80) |=> (pin_oe == 24'hFFFFFF));

  // R5
  tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_wr && bus_addr == A_P3 && !bus_wdata[7]) |=> (pin_oe == 24'h0));

  // R8
  board_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brd_rst |=> (pin_out == 24'h0 && pin_oe == 24'h0));

  // R9
  timer_page_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_q && !ctl_wr) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/dio24_paged_port_bench.sv
module dio24_paged_port_bench;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [23:0] pin_in, pin_out, pin_oe, ext = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  dio24_paged_port u_dio24_paged_port (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [23:0] exp_oe(input logic [7:0] c);
    logic e = c[7];
    return { {4{e & ~c[3]}}, {4{e & ~c[0]}}, {8{e & ~c[1]}}, {8{e & ~c[4]}} };
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [23:0] lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 oe", pin_oe, 0); chk("R1 out", pin_out, 0);
    rd(4'hD, r); chk("R1 timer page scratch", r, 0);
    wr(4'h8, 8'h01);
    rd(4'hF, r); chk("R1 cfg", r, 8'h9B);
    // R9
    wr(4'h8, 8'h00);
    wr(4'hD, 8'h11); wr(4'hE, 8'h22); wr(4'hF, 8'h33); wr(4'hC, 8'h55);
    rd(4'hD, r); chk("R9 scratch0", r, 8'h11);
    rd(4'hE, r); chk("R9 scratch1", r, 8'h22);
    rd(4'hF, r); chk("R9 scratch2", r, 8'h33);
    rd(4'hC, r); chk("R9 0x0C on timer page", r, 0);
    chk("R9 latches untouched", pin_out, 0);
    // R2 R3
    wr(4'h8, 8'h01);
    rd(4'hF, r); chk("R9 cfg untouched", r, 8'h9B);
    wr(4'hC, 8'hA5); wr(4'hD, 8'h3C); wr(4'hE, 8'hF0);
    chk("R3 latches", pin_out, 24'hF03CA5);
    wr(4'h8, 8'h00);
    rd(4'hD, r); chk("R2 back on timer page", r, 8'h11);
    wr(4'h8, 8'h01);
    lat = 24'hF03CA5;
    // R4 R6 sweep over all direction patterns, enabled and disabled
    for (int en = 1; en >= 0; en--) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] c;
        c = {en[0], 3'b000, k[3], 1'b0, k[1], k[0]};
        c[4] = k[2];
        wr(4'hF, c);
        chk(en ? "R4 oe" : "R5 oe", pin_oe, exp_oe(c));
        for (int p = 0; p < 2; p++) begin
          logic [23:0] pad;
          ext = p ? 24'h5AC3E1 : ~24'h5AC3E1;
          pad = (exp_oe(c) & lat) | (~exp_oe(c) & ext);
          for (int b = 0; b < 3; b++) begin
            rd(4'hC + 4'(b), r);
            chk("R6 readback", r, pad[8*b +: 8]);
          end
        end
      end
    end
    // R7
    ext = 24'h000000;
    wr(4'hF, 8'h9B);
    wr(4'hC, 8'h56); wr(4'hD, 8'h34); wr(4'hE, 8'h12);
    rd(4'hC, r); chk("R7 input reads pad", r, 8'h00);
    wr(4'hF, 8'h80);
    rd(4'hC, r); chk("R7 A driven", r, 8'h56);
    rd(4'hD, r); chk("R7 B driven", r, 8'h34);
    rd(4'hE, r); chk("R7 C driven", r, 8'h12);
    // R8
    wr(4'h8, 8'h20);
    chk("R8 latches", pin_out, 0); chk("R8 oe", pin_oe, 0);
    rd(4'hD, r); chk("R8 page timer", r, 8'h11);
    wr(4'h8, 8'h01);
    rd(4'hF, r); chk("R8 cfg", r, 8'h9B);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule